// File: doc/BRIEF.md
# Parity-Preserving Reversible Gate Unit

This block evaluates one of five reversible logic gates on a 4-line input vector, in a single combinational pass. A 3-bit opcode picks the gate. Three gates use three lines and two use all four. A direction bit chooses between the forward mapping and its inverse. Every gate is a bijection whose output parity equals its input parity, so the inverse always exists and a single corrupted output line shows up as a parity mismatch.

The unit compares the XOR of the input lines with the XOR of the delivered output lines. The result is an online fault flag. A fault-injection mask XORs onto the gate result before it reaches the output, so a testbench can corrupt chosen lines and watch the flag respond. Opcodes outside the five legal values give an all-zero gate result and raise an illegal-opcode indication.

The inverse can be built in two ways, chosen by a parameter. One is a preimage search over the forward map. The other is a closed-form set of equations for each gate.

Top module: `rpg_gate_unit`

## Requirements
- R1: Input lines are vec_in bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D. Output lines are vec_out bit 0 = P, bit 1 = Q, bit 2 = R, bit 3 = S. Opcode 0 (fanout XOR) gives P=A, Q=A^B, R=A^C.
- R2: Opcode 1 (controlled swap) gives P=A. When A=0 it gives Q=B and R=C. When A=1 it gives Q=C and R=B.
- R3: Opcode 2 (fault-tolerant gate) gives P=A^B, Q=(~B&C)^(A&~C), R=(B&C)^(A&~C).
- R4: Opcode 3 (four-line gate one) gives P=~(A^B), Q=~B, R=(~B&C)^(B&D), S=(~B&D)^(B&~C).
- R5: Opcode 4 (four-line gate two) gives P=(A&~C)^(B&C), Q=~(A^B), R=~C, S=(A&~C)^(B&C)^D.
- R6: For opcodes 0, 1 and 2, output bit 3 equals input bit 3. Line D still counts in both parity sums.
- R7: With inv_mode=1 the gate result is the unique vector whose forward image is vec_in. For every legal opcode and all 16 vectors, applying the inverse to a forward result gives back the original vector. Forward mode (inv_mode=0) is a one-to-one mapping.
- R8: For any legal opcode, in either direction, fault_flag is 0 while inj_mask is zero.
- R9: vec_out is the gate result XOR inj_mask. fault_flag is the XOR of all vec_in bits XOR all vec_out bits. So for a legal opcode, a mask of odd weight raises fault_flag and a mask of even weight leaves it low.
- R10: Opcodes 5, 6 and 7 give an all-zero gate result and op_illegal=1. Opcodes 0 to 4 give op_illegal=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Gate opcode, legal values 0 to 4 |
| inv_mode | input | 1 | 0 = forward mapping, 1 = inverse mapping |
| vec_in | input | 4 | Input lines A (bit 0) to D (bit 3) |
| inj_mask | input | 4 | Fault-injection mask XORed onto the gate result |
| vec_out | output | 4 | Output lines P (bit 0) to S (bit 3) after the mask |
| fault_flag | output | 1 | High when input parity differs from output parity |
| op_illegal | output | 1 | High for opcodes 5 to 7 |

## Verification
Each legal gate is swept over all 16 input vectors in forward mode and compared against bench equations. This separates the five gates from each other and catches any swapped or inverted output line. Each forward result is then fed back through inverse mode, which shows that the two directions pair up and that no two inputs collide. Mask sweeps over all 16 patterns on fixed vectors tell odd-weight corruption, which must raise the flag, apart from even-weight corruption, which the parity check cannot see. Sweeps of the unused opcodes show that the gate result goes to zero while the mask and flag keep working.

// File: rtl/rpg_pkg.sv
`timescale 1ns/1ps
package rpg_pkg;

   localparam int unsigned RPG_LINES     = 4;
   localparam int unsigned RPG_OP_W      = 3;
   localparam int unsigned RPG_NUM_GATES = 5;

   typedef logic [RPG_LINES-1:0] vec_t;

   typedef enum logic [RPG_OP_W-1:0] {
      OP_FANXOR = 3'd0,
      OP_CSWAP  = 3'd1,
      OP_FTOL   = 3'd2,
      OP_MIX1   = 3'd3,
      OP_MIX2   = 3'd4
   } gate_op_e;

   // Forward mapping of every gate; unused opcodes map to zero.
   function automatic vec_t rpg_fwd_map(input logic [RPG_OP_W-1:0] op, input vec_t x);
      logic a, b, c, d, sel;
      vec_t y;
      a = x[0]; b = x[1]; c = x[2]; d = x[3];
      y = '0;
      case (op)
         OP_FANXOR: y = {d, a ^ c, a ^ b, a};
         OP_CSWAP:  y = {d, (~a & c) ^ (a & b), (~a & b) ^ (a & c), a};
         OP_FTOL:   y = {d, (b & c) ^ (a & ~c), (~b & c) ^ (a & ~c), a ^ b};
         OP_MIX1:   y = {(~b & d) ^ (b & ~c), (~b & c) ^ (b & d), ~b, ~(a ^ b)};
         OP_MIX2: begin
            sel = (a & ~c) ^ (b & c);
            y   = {sel ^ d, ~c, ~(a ^ b), sel};
         end
         default:   y = '0;
      endcase
      return y;
   endfunction

endpackage

// File: rtl/rpg_fwd_eval.sv
`timescale 1ns/1ps
module rpg_fwd_eval #(
   parameter int unsigned LINES = 4,
   parameter int unsigned OP_W  = 3
) (
   input  logic [OP_W-1:0]  op,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   always_comb dout = rpg_pkg::rpg_fwd_map(op, din);
endmodule

// File: rtl/rpg_inv_eval.sv
`timescale 1ns/1ps
module rpg_inv_eval #(
   parameter int unsigned LINES      = 4,
   parameter int unsigned OP_W       = 3,
   parameter bit          INV_SEARCH = 1'b1
) (
   input  logic [OP_W-1:0]  op,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   localparam int unsigned NUM_VEC = 1 << LINES;

   if (INV_SEARCH) begin : g_search
      logic [NUM_VEC-1:0] hit;
      for (genvar k = 0; k < NUM_VEC; k++) begin : g_cand
         assign hit[k] = (rpg_pkg::rpg_fwd_map(op, LINES'(k)) == din);
      end
      always_comb begin
         dout = '0;
         for (int i = 0; i < NUM_VEC; i++) begin
            if (hit[i]) dout = dout | LINES'(i);
         end
      end
   end else begin : g_closed
      logic p, q, r, s;
      assign p = din[0];
      assign q = din[1];
      assign r = din[2];
      assign s = din[3];
      always_comb begin
         dout = '0;
         case (op)
            rpg_pkg::OP_FANXOR: dout = {s, p ^ r, p ^ q, p};
            rpg_pkg::OP_CSWAP:  dout = p ? {s, q, r, p} : {s, r, q, p};
            rpg_pkg::OP_FTOL:   dout = (q ^ r) ? {s, 1'b1, r, p ^ r}
                                               : {s, 1'b0, p ^ q, q};
            rpg_pkg::OP_MIX1:   dout = q ? {s, r, 1'b0, p ^ q}
                                         : {r, ~s, 1'b1, p ^ q};
            rpg_pkg::OP_MIX2:   dout = r ? {s ^ p, 1'b0, p ^ ~q, p}
                                         : {s ^ p, 1'b1, p, p ^ ~q};
            default:            dout = '0;
         endcase
      end
   end
endmodule

// File: rtl/rpg_parity_mon.sv
`timescale 1ns/1ps
module rpg_parity_mon #(
   parameter int unsigned LINES = 4
) (
   input  logic [LINES-1:0] din,
   input  logic [LINES-1:0] raw,
   input  logic [LINES-1:0] mask,
   output logic [LINES-1:0] dout,
   output logic             mismatch
);
   logic par_in, par_out;
   assign dout     = raw ^ mask;
   assign par_in   = ^din;
   assign par_out  = ^dout;
   assign mismatch = par_in ^ par_out;
endmodule

// File: rtl/rpg_gate_unit.sv
`timescale 1ns/1ps
module rpg_gate_unit #(
   parameter int unsigned LINES      = 4,
   parameter int unsigned OP_W       = 3,
   parameter int unsigned NUM_GATES  = 5,
   parameter bit          INV_SEARCH = 1'b1
) (
   input  logic [2:0] op_sel,
   input  logic       inv_mode,
   input  logic [3:0] vec_in,
   input  logic [3:0] inj_mask,
   output logic [3:0] vec_out,
   output logic       fault_flag,
   output logic       op_illegal
);
   localparam logic [OP_W-1:0] LAST_OP = OP_W'(NUM_GATES - 1);

   if (LINES != rpg_pkg::RPG_LINES) begin : g_bad_lines
      $error("rpg_gate_unit: LINES must match the gate library width");
   end
   if (OP_W != rpg_pkg::RPG_OP_W) begin : g_bad_opw
      $error("rpg_gate_unit: OP_W must match the opcode width");
   end
   if (NUM_GATES != rpg_pkg::RPG_NUM_GATES) begin : g_bad_gates
      $error("rpg_gate_unit: NUM_GATES must match the gate library");
   end

   logic [LINES-1:0] fwd_res, inv_res, gate_res;

   rpg_fwd_eval #(.LINES(LINES), .OP_W(OP_W)) u_fwd (
      .op(op_sel), .din(vec_in), .dout(fwd_res)
   );

   rpg_inv_eval #(.LINES(LINES), .OP_W(OP_W), .INV_SEARCH(INV_SEARCH)) u_inv (
      .op(op_sel), .din(vec_in), .dout(inv_res)
   );

   assign op_illegal = (op_sel > LAST_OP);
   assign gate_res   = op_illegal ? '0 : (inv_mode ? inv_res : fwd_res);

   rpg_parity_mon #(.LINES(LINES)) u_par (
      .din(vec_in), .raw(gate_res), .mask(inj_mask),
      .dout(vec_out), .mismatch(fault_flag)
   );
endmodule

// File: rtl/rpg_gate_unit_chk.sv
`timescale 1ns/1ps
module rpg_gate_unit_chk #(
   parameter int unsigned NUM_GATES = 5
) (
   input logic [2:0] op_sel,
   input logic       inv_mode,
   input logic [3:0] vec_in,
   input logic [3:0] inj_mask,
   input logic [3:0] vec_out,
   input logic       fault_flag,
   input logic       op_illegal
);
   localparam logic [2:0] LAST_OP = 3'(NUM_GATES - 1);

   always_comb begin
      // R8: clean mask and a legal gate keep parity
      assert_parity_kept_R8: assert (op_illegal || (inj_mask != 4'd0) || !fault_flag)
         else $error("parity lost without injection");
      // R9: odd-weight mask is always seen on a legal gate
      assert_odd_mask_seen_R9: assert (op_illegal || !(^inj_mask) || fault_flag)
         else $error("odd mask not flagged");
      // R6: three-line gates leave line D alone
      assert_line_d_pass_R6: assert ((op_sel > 3'd2) || inj_mask[3] || (vec_out[3] == vec_in[3]))
         else $error("line D altered");
      // R10: illegal opcode gives zero result
      assert_illegal_zero_R10: assert (!op_illegal || (inj_mask != 4'd0) || (vec_out == 4'd0))
         else $error("illegal opcode produced data");
      // R10: legal opcodes never flagged illegal
      assert_legal_ok_R10: assert ((op_sel > LAST_OP) || !op_illegal)
         else $error("legal opcode flagged");
      // R1, R2: fanout and swap gates carry A to P
      assert_ctrl_line_R1: assert ((op_sel > 3'd1) || inj_mask[0] || (vec_out[0] == vec_in[0]))
         else $error("control line not carried");
   end
endmodule

bind rpg_gate_unit rpg_gate_unit_chk #(.NUM_GATES(NUM_GATES)) u_chk (
   .op_sel(op_sel), .inv_mode(inv_mode), .vec_in(vec_in), .inj_mask(inj_mask),
   .vec_out(vec_out), .fault_flag(fault_flag), .op_illegal(op_illegal)
);

// File: tb/rpg_gate_unit_bench.sv
`timescale 1ns/1ps
module rpg_gate_unit_bench;
   logic       clk = 1'b0;
   logic [2:0] op_sel = 3'd0;
   logic       inv_mode = 1'b0;
   logic [3:0] vec_in = 4'd0;
   logic [3:0] inj_mask = 4'd0;
   logic [3:0] vec_out;
   logic       fault_flag, op_illegal;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rpg_gate_unit u_rpg_gate_unit (
      .op_sel(op_sel), .inv_mode(inv_mode), .vec_in(vec_in), .inj_mask(inj_mask),
      .vec_out(vec_out), .fault_flag(fault_flag), .op_illegal(op_illegal)
   );

   // Independent model of the forward equations.
   function automatic logic [3:0] model_fwd(input int op, input logic [3:0] x);
      logic a, b, c, d, p;
      a = x[0]; b = x[1]; c = x[2]; d = x[3];
      case (op)
         0: return {d, a ^ c, a ^ b, a};
         1: return {d, a ? b : c, a ? c : b, a};
         2: return {d, c ? b : a, c ? ~b : a, a ^ b};
         3: return {b ? ~c : d, b ? d : c, ~b, ~(a ^ b)};
         4: begin p = c ? b : a; return {p ^ d, ~c, ~(a ^ b), p}; end
         default: return 4'd0;
      endcase
   endfunction

   task automatic apply(input int op, input bit inv, input logic [3:0] x, input logic [3:0] m);
      @(negedge clk);
      op_sel = 3'(op); inv_mode = inv; vec_in = x; inj_mask = m;
      #1;
   endtask

   task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (op %0d inv %0b in %h mask %h)",
                  req, act, exp, op_sel, inv_mode, vec_in, inj_mask);
      end
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b (op %0d inv %0b in %h mask %h)",
                  req, act, exp, op_sel, inv_mode, vec_in, inj_mask);
      end
   endtask

   task automatic t_start_state();
      apply(0, 1'b0, 4'd0, 4'd0);
      chk4("R1 idle output", vec_out, 4'd0);
      chk1("R8 idle flag", fault_flag, 1'b0);
      chk1("R10 idle legal", op_illegal, 1'b0);
   endtask

   task automatic t_forward_all();
      string tag [5] = '{"R1", "R2", "R3", "R4", "R5"};
      for (int op = 0; op < 5; op++) begin
         for (int v = 0; v < 16; v++) begin
            apply(op, 1'b0, 4'(v), 4'd0);
            chk4(tag[op], vec_out, model_fwd(op, 4'(v)));
            chk1("R8 forward parity", fault_flag, 1'b0);
            chk1("R10 legal opcode", op_illegal, 1'b0);
         end
      end
   endtask

   task automatic t_line_d();
      for (int op = 0; op < 3; op++) begin
         for (int v = 0; v < 16; v++) begin
            apply(op, 1'b0, 4'(v), 4'd0);
            chk1("R6 line D forward", vec_out[3], v[3]);
            apply(op, 1'b1, 4'(v), 4'd0);
            chk1("R6 line D inverse", vec_out[3], v[3]);
         end
      end
   endtask

   task automatic t_round_trip();
      for (int op = 0; op < 5; op++) begin
         logic [15:0] seen = '0;
         for (int v = 0; v < 16; v++) begin
            logic [3:0] y;
            apply(op, 1'b0, 4'(v), 4'd0);
            y = vec_out;
            seen[y] = 1'b1;
            apply(op, 1'b1, y, 4'd0);
            chk4("R7 inverse of forward", vec_out, 4'(v));
            chk1("R8 inverse parity", fault_flag, 1'b0);
         end
         chk4("R7 bijective lower", seen[3:0], 4'hf);
         chk4("R7 bijective upper", seen[15:12], 4'hf);
      end
   endtask

   task automatic t_inject();
      logic [3:0] pick [3] = '{4'h0, 4'h9, 4'h6};
      for (int op = 0; op < 5; op += 2) begin
         for (int j = 0; j < 3; j++) begin
            for (int m = 0; m < 16; m++) begin
               apply(op, 1'b0, pick[j], 4'(m));
               chk4("R9 masked output", vec_out, model_fwd(op, pick[j]) ^ 4'(m));
               chk1("R9 flag vs mask weight", fault_flag, ^(4'(m)));
            end
         end
      end
      apply(3, 1'b1, 4'h5, 4'h7);
      chk1("R9 inverse odd mask", fault_flag, 1'b1);
      apply(3, 1'b1, 4'h5, 4'h3);
      chk1("R9 inverse even mask", fault_flag, 1'b0);
   endtask

   task automatic t_illegal();
      for (int op = 5; op < 8; op++) begin
         for (int v = 0; v < 16; v += 3) begin
            apply(op, v[0], 4'(v), 4'd0);
            chk4("R10 illegal zero", vec_out, 4'd0);
            chk1("R10 illegal flag", op_illegal, 1'b1);
            chk1("R9 illegal parity", fault_flag, ^(4'(v)));
            apply(op, 1'b0, 4'(v), 4'hb);
            chk4("R9 illegal masked", vec_out, 4'hb);
         end
      end
   endtask

   initial begin
      t_start_state();
      t_forward_all();
      t_line_d();
      t_round_trip();
      t_inject();
      t_illegal();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule